// File: doc/BRIEF.md
# Independent-Channel Rail Enable Controller

This block controls four supply rails that come up in an order set by their voltages rather than by timers. Once the shared active-low enable is asserted, each rail enable turns on as soon as that channel's own undervoltage-good input is valid. The other channels have no effect on it, so a chain of rails where each one feeds the next channel's monitor comes up in voltage order. An active-low reset-done output goes high a fixed delay after every rail reports that its switch is fully enhanced.

A rail that later drops out pulls reset-done low and turns off only its own enable; the other rails keep running. When the rail recovers, reset-done is released again after the full delay. Deasserting the enable latches reset-done low and starts an ordered turn-off: each rail drops when its own programmed off-delay expires. That turn-off always runs to the end. The controller arms again only after the enable has been seen deasserted and then asserted.

The undervoltage and enable inputs pass through a persistence filter before they are acted on. The controller is built around four states:
- IDLE moves to RUN when the enable is asserted.
- RUN moves to DRAIN when the enable is deasserted.
- DRAIN moves to REARM when every off-timer has expired.
- REARM moves to IDLE when the enable is deasserted.

Top module: `rail_indep_seq`

## Requirements
Timings are counted in rising clock edges after an input changes. F = FILT_CYCLES and T = RST_DLY_CYCLES. d_i = off_dly_in[i*OFF_W +: OFF_W]. en_n_in low means enabled.

- R1: While enabled, rail_en_out[i] depends only on channel i's own filtered undervoltage input. A channel whose input is not good stays low whatever the other channels do. Enabling with an input already good turns that rail on at edge F+2 after en_n_in falls.
- R2: There is no on-delay. While running, rail_en_out[i] rises at edge F+1 after uv_ok_in[i] rises.
- R3: rst_done_n_out rises at edge T after all of rail_full_in are high, provided the block is running, enabled and every undervoltage input is good. It is low before that edge.
- R4: When uv_ok_in[i] drops and stays low for at least F cycles, rail_en_out[i] and rst_done_n_out fall at edge F+1 and the other rails stay on. When the input recovers, the rail comes back at edge F+1 and rst_done_n_out is released at edge F+T.
- R5: When en_n_in rises, rst_done_n_out falls at edge F+1 and rail_en_out[i] falls at edge F+2+d_i.
- R6: A pulse shorter than F cycles on uv_ok_in or en_n_in changes no output.
- R7: Once turn-off has started, changes on uv_ok_in neither move a rail's drop time nor turn a rail back on.
- R8: After turn-off completes, the rails stay off, even with the enable asserted, until en_n_in has been high for F cycles and then low again. Re-enabling then behaves as in R1.
- R9: If any rail_full_in drops before the reset-done delay expires, the count restarts from zero, and release comes at edge T after the last of them is high again.
- R10: While rst_n is low, all rail enables and rst_done_n_out are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n_in | input | 1 | Shared enable, active low |
| uv_ok_in | input | NUM_CH | Per-rail undervoltage-good, high when the supply is above its level |
| rail_full_in | input | NUM_CH | Per-rail fully-enhanced feedback |
| off_dly_in | input | NUM_CH*OFF_W | Per-rail off-delay in cycles, channel i at bits [i*OFF_W +: OFF_W] |
| rail_en_out | output | NUM_CH | Per-rail enable |
| rst_done_n_out | output | 1 | Reset-done, high once the rails are settled |

## Verification
Some properties are checked on every cycle:
- A filtered input only ever takes on the raw value it was given.
- A rail rises only from its own good input while running.
- A rail falls while running only because its own input failed.
- No rail rises during the turn-off.
- Reset-done is high only when the feedback was fully enhanced, and stays low through the turn-off.
- The rails are off in IDLE and REARM.

The exact edge counts need the bench's scenarios. These cover the on-time after a supply becomes good, the release delay and its restart, the per-rail drop times across a sweep of off-delay settings and turn-on orders, glitch rejection, and the re-arm rule.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for enable
        ST_RUN   = 2'd1,   // rails follow their own supply-good inputs
        ST_DRAIN = 2'd2,   // timed turn-off in progress
        ST_REARM = 2'd3    // turn-off done, waiting for enable release
    } seq_state_e;

endpackage

// File: rtl/rail_seq_deglitch.sv
// Persistence filter: the output takes the input value only after the
// input has differed from it for FILT_CYCLES consecutive cycles.
module rail_seq_deglitch #(
    parameter int   FILT_CYCLES = 3000,
    parameter logic RESET_VAL   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clean_out <= RESET_VAL;
            cnt_q     <= '0;
        end else if (raw_in == clean_out) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            clean_out <= raw_in;
            cnt_q     <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rail_seq_done_timer.sv
// Settling timer: done goes high DELAY_CYCLES edges after arm rises and
// clears (with the count) whenever arm drops.
module rail_seq_done_timer #(
    parameter int DELAY_CYCLES = 15_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic done
);
    localparam int CW = $clog2(DELAY_CYCLES + 1);
    localparam logic [CW-1:0] LIM    = CW'(DELAY_CYCLES);
    localparam logic [CW-1:0] LIM_M1 = CW'(DELAY_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (!arm) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            if (cnt_q != LIM) begin
                cnt_q <= cnt_q + 1'b1;
            end
            done <= (cnt_q >= LIM_M1);
        end
    end
endmodule

// File: rtl/rail_seq_off_timer.sv
// Per-rail turn-off countdown: reloads while load is high, counts down
// while run is high, and reports expiry once it reaches zero.
module rail_seq_off_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] delay_in,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= delay_in;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/rail_indep_seq.sv
module rail_indep_seq
    import rail_seq_pkg::*;
#(
    parameter int NUM_CH         = 4,
    parameter int FILT_CYCLES    = 3000,
    parameter int RST_DLY_CYCLES = 15_000_000,
    parameter int OFF_W          = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_n_in,
    input  logic [NUM_CH-1:0]       uv_ok_in,
    input  logic [NUM_CH-1:0]       rail_full_in,
    input  logic [NUM_CH*OFF_W-1:0] off_dly_in,
    output logic [NUM_CH-1:0]       rail_en_out,
    output logic                    rst_done_n_out
);
    seq_state_e        state_q, state_d;
    logic [NUM_CH-1:0] uv_f;
    logic              en_n_f;
    logic              en_on;
    logic [NUM_CH-1:0] off_expired;
    logic [NUM_CH-1:0] rail_d;
    logic              settle_arm;

    // Input filtering: one filter per supply-good input, plus the enable
    for (genvar i = 0; i < NUM_CH; i++) begin : g_uv_filt
        rail_seq_deglitch #(
            .FILT_CYCLES(FILT_CYCLES),
            .RESET_VAL  (1'b0)
        ) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (uv_ok_in[i]),
            .clean_out(uv_f[i])
        );
    end

    rail_seq_deglitch #(
        .FILT_CYCLES(FILT_CYCLES),
        .RESET_VAL  (1'b1)
    ) u_en_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (en_n_in),
        .clean_out(en_n_f)
    );

    assign en_on = !en_n_f;

    // Per-rail off-delay counters: reload while running, count down in DRAIN
    for (genvar i = 0; i < NUM_CH; i++) begin : g_off
        rail_seq_off_timer #(
            .W(OFF_W)
        ) u_off (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (state_q == ST_RUN),
            .run     (state_q == ST_DRAIN),
            .delay_in(off_dly_in[i*OFF_W +: OFF_W]),
            .expired (off_expired[i])
        );
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en_on)           state_d = ST_RUN;
            ST_RUN:   if (!en_on)          state_d = ST_DRAIN;
            ST_DRAIN: if (&off_expired)    state_d = ST_REARM;
            ST_REARM: if (!en_on)          state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Rail enable outputs
    always_comb begin
        rail_d = '0;
        unique case (state_q)
            ST_RUN:   rail_d = uv_f;
            ST_DRAIN: rail_d = rail_en_out & ~off_expired;
            default:  rail_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rail_en_out <= '0;
        end else begin
            rail_en_out <= rail_d;
        end
    end

    // Reset-done timing: runs only while fully up and enabled
    assign settle_arm = (state_q == ST_RUN) && en_on && (&uv_f) && (&rail_full_in);

    rail_seq_done_timer #(
        .DELAY_CYCLES(RST_DLY_CYCLES)
    ) u_done (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (settle_arm),
        .done (rst_done_n_out)
    );
endmodule

// File: rtl/rail_indep_seq_chk.sv
module rail_indep_seq_chk
    import rail_seq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] uv_raw,
    input logic [NUM_CH-1:0] uv_f,
    input logic [NUM_CH-1:0] rail_en,
    input logic [NUM_CH-1:0] full,
    input seq_state_e        state,
    input logic              rst_done_n
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        AST_RISE_FROM_OWN_UV: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rail_en[i]) |-> ($past(uv_f[i]) && ($past(state) == ST_RUN))); // R1
        AST_FALL_ONLY_OWN_UV: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(rail_en[i]) && ($past(state) == ST_RUN)) |-> !$past(uv_f[i])); // R4
        AST_NO_RISE_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(state) == ST_DRAIN) |-> !$rose(rail_en[i])); // R7
        AST_FILT_TAKES_RAW: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(uv_f[i]) |-> (uv_f[i] == $past(uv_raw[i]))); // R6
    end

    AST_DONE_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done_n |-> $past(&full)); // R3

    AST_DRAIN_HOLDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> !rst_done_n); // R5

    AST_PARKED_RAILS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (((state == ST_IDLE) || (state == ST_REARM)) && ($past(state) != ST_RUN))
        |-> (rail_en == '0)); // R8
endmodule

bind rail_indep_seq rail_indep_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .uv_raw    (uv_ok_in),
    .uv_f      (uv_f),
    .rail_en   (rail_en_out),
    .full      (rail_full_in),
    .state     (state_q),
    .rst_done_n(rst_done_n_out)
);

// File: tb/rail_indep_seq_test.sv
`timescale 1ns/1ps
module rail_indep_seq_test;
    localparam int N = 4;
    localparam int F = 4;
    localparam int T = 20;
    localparam int W = 6;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           en_n;
    logic [N-1:0]   uv;
    logic [N-1:0]   full;
    logic [N*W-1:0] dly;
    logic [N-1:0]   rails;
    logic           rstd;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rail_indep_seq #(
        .NUM_CH(N), .FILT_CYCLES(F), .RST_DLY_CYCLES(T), .OFF_W(W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .en_n_in(en_n), .uv_ok_in(uv),
        .rail_full_in(full), .off_dly_in(dly),
        .rail_en_out(rails), .rst_done_n_out(rstd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        int d [N];
        int maxd;
        int ch;
        logic [N-1:0] exp_on;
        rst_n = 1'b0; en_n = 1'b1; uv = '0; full = '0; dly = '0;
        step(3);
        chk("R10 rails in reset", 32'(rails), 0);
        chk("R10 reset-done in reset", 32'(rstd), 0);
        rst_n = 1'b1;
        step(2);

        for (int p = 0; p < 6; p++) begin
            maxd = 0;
            for (int i = 0; i < N; i++) begin
                d[i] = (p * 11 + i * 7) % 23;
                dly[i*W +: W] = W'(d[i]);
                if (d[i] > maxd) maxd = d[i];
            end
            uv = '0; full = '0; en_n = 1'b0;
            step(F + 2);
            chk("R1 no rail without own supply", 32'(rails), 0);

            // voltage-ordered turn-on, order varies with p
            exp_on = '0;
            for (int j = 0; j < N; j++) begin
                ch = (j * 3 + p) % N;
                uv[ch] = 1'b1;
                step(F);
                chk("R2 rail not yet on", 32'(rails), 32'(exp_on));
                step(1);
                exp_on[ch] = 1'b1;
                chk("R1 R2 own rail on at F+1", 32'(rails), 32'(exp_on));
            end

            full = '1;
            if (p % 2 == 1) begin
                step(T / 2);
                chk("R9 still settling", 32'(rstd), 0);
                full[p % N] = 1'b0;
                step(1);
                full[p % N] = 1'b1;
            end
            step(T - 1);
            chk("R3 R9 low before delay", 32'(rstd), 0);
            step(1);
            chk("R3 R9 released at delay", 32'(rstd), 1);

            if (p == 2) begin
                uv[1] = 1'b0;
                step(F);
                chk("R4 rails before fault seen", 32'(rails), 32'hF);
                chk("R4 reset-done before fault seen", 32'(rstd), 1);
                step(1);
                chk("R4 only faulted rail off", 32'(rails), 32'hD);
                chk("R4 reset-done low on fault", 32'(rstd), 0);
                uv[1] = 1'b1;
                step(F + 1);
                chk("R4 rail recovers", 32'(rails), 32'hF);
                step(T - 2);
                chk("R4 reset-done still low", 32'(rstd), 0);
                step(1);
                chk("R4 reset-done re-released", 32'(rstd), 1);
            end

            if (p == 3) begin
                uv[0] = 1'b0;
                step(F - 1);
                uv[0] = 1'b1;
                step(2 * F);
                chk("R6 supply glitch rails", 32'(rails), 32'hF);
                chk("R6 supply glitch reset-done", 32'(rstd), 1);
                en_n = 1'b1;
                step(F - 1);
                en_n = 1'b0;
                step(2 * F);
                chk("R6 enable glitch rails", 32'(rails), 32'hF);
                chk("R6 enable glitch reset-done", 32'(rstd), 1);
            end

            // timed turn-off
            en_n = 1'b1;
            for (int k = 1; k <= F + 3 + maxd; k++) begin
                step(1);
                for (int i = 0; i < N; i++) exp_on[i] = (k < F + 2 + d[i]);
                chk((p == 4) ? "R7 drop time with supply change" : "R5 rail drop time",
                    32'(rails), 32'(exp_on));
                chk("R5 reset-done during turn-off", 32'(rstd), (k < F + 1) ? 1 : 0);
                if (p == 4 && k == F + 3) uv = '0;
                if (p == 5 && k == F + 2) en_n = 1'b0;
            end

            if (p == 5) begin
                step(F + 5);
                chk("R8 no restart without release", 32'(rails), 0);
                en_n = 1'b1;
                step(F + 2);
                en_n = 1'b0;
                step(F + 1);
                chk("R8 R1 not on before F+2", 32'(rails), 0);
                step(1);
                chk("R8 R1 re-armed rails on", 32'(rails), 32'hF);
                en_n = 1'b1;
                step(F + 3 + maxd + 2);
                chk("R8 second turn-off done", 32'(rails), 0);
            end

            en_n = 1'b1; uv = '0; full = '0;
            step(F + 4);
        end

        summary();
        $finish;
    end
endmodule